// File: doc/BRIEF.md
# Bank-Switching Address Mapper

This block sits between a CPU, a video fetch unit and three external memories: a large program ROM, a pattern ROM and a small nametable RAM. It turns the 16-bit CPU address into a program ROM address by substituting one of several 8 KB bank numbers. It turns the video pattern address into a pattern ROM address by substituting 1 KB or 2 KB bank numbers. It folds the nametable address into a 2 KB RAM according to a mirroring bit. It also gates an 8 KB work RAM at CPU addresses 0x6000-0x7FFF.

Software programs the block with CPU writes to the upper half of the address space. Most bank registers are loaded in two steps: the first write picks a target register and two layout modes, and the second write loads the picked register. The program mode decides which of two program windows is fixed to the second-last bank. The pattern mode decides whether the 2 KB banks sit in the lower or the upper pattern half. All translation paths are combinational. Register state changes only on a clock edge with the write strobe high.

Top module: `bank_mapper`

## Requirements
- R1: A clocked write whose address has bits {15,14,13,0} = {1,0,0,0} (base 0x8000) loads the pattern mode from data bit 7, the program mode from data bit 6 and the register select from data bits 2:0.
- R2: A clocked write with address bits {15,14,13,0} = {1,0,0,1} (base 0x8001) loads the selected bank register. Selects 0 and 1 store the byte with bit 0 cleared, selects 2 to 5 store the full byte, and selects 6 and 7 store only bits 5:0.
- R3: Only address bits 15, 14, 13 and 0 are decoded, so 0x9FFE acts as 0x8000 and 0xBFFE acts as 0xA000. Writes with address bit 15 low, writes with the strobe low, and writes to the 0xC000/0xE000 groups leave every mapping output unchanged.
- R4: Program ROM address = {bank, cpu_addr[12:0]}, where window cpu_addr[14:13] = 3 always uses bank 0x3F and window 1 always uses bank register 7.
- R5: With program mode 0, window 0 uses register 6 and window 2 uses bank 0x3E. With program mode 1, window 0 uses 0x3E and window 2 uses register 6.
- R6: With pattern mode 0, video 0x0000-0x07FF and 0x0800-0x0FFF map through registers 0 and 1 as {bank,10'b0} | addr[10:0]. Video 0x1000-0x1FFF maps through registers 2, 3, 4 and 5 (by addr[11:10]) as {bank, addr[9:0]}.
- R7: With pattern mode 1, the four 1 KB banks (registers 2 to 5) cover 0x0000-0x0FFF and the two 2 KB banks (registers 0 and 1) cover 0x1000-0x1FFF, with the same address forms as R6.
- R8: A write with address bits {15,14,13,0} = {1,0,1,0} (base 0xA000) loads mirroring from data bit 0. The nametable address is {vid_addr[10], vid_addr[9:0]} when mirroring is 0 and {vid_addr[11], vid_addr[9:0]} when it is 1.
- R9: A write with address bits {15,14,13,0} = {1,0,1,1} (base 0xA001) loads the RAM enable from data bit 7 and the write protect from data bit 6. wram_rd_en = cpu_rd and cpu_addr in 0x6000-0x7FFF and enabled. wram_wr_en = wr_en and wr_addr in 0x6000-0x7FFF and enabled and not protected. wram_rdata_gated is wram_rdata when enabled and 0x00 otherwise.
- R10: Reset clears both modes, the select, all eight bank registers and mirroring, sets the RAM enable and clears the write protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 16 | CPU address for program and work RAM lookup |
| vid_addr | input | 14 | Video fetch address |
| wram_rdata | input | 8 | Data read from the work RAM |
| prg_rom_addr | output | 19 | Physical program ROM address |
| chr_rom_addr | output | 18 | Physical pattern ROM address |
| nt_addr | output | 11 | Nametable RAM address |
| wram_rd_en | output | 1 | Work RAM read enable |
| wram_wr_en | output | 1 | Work RAM write enable |
| wram_rdata_gated | output | 8 | Work RAM read data after the enable gate |

## Verification
Every translation path is combinational, so a wrong bank register, mode bit or mirroring bit appears at the ROM or RAM address ports in the same cycle that any address reaches the affected window. A bad register write therefore shows up one clock after the write. The tests sweep both program windows and all six pattern regions in both modes, using bank values whose masked bits differ from the raw data, so a mask or routing error changes an address bit. Writes that must be ignored are followed right away by lookups of the regions they could have disturbed.

// File: rtl/bmap_pkg.sv
package bmap_pkg;

   // Offset widths follow from the fixed 8 KB program and 1 KB pattern granules
   localparam int unsigned PRG_OFS_W  = 13;
   localparam int unsigned CHR_OFS_W  = 10;
   localparam int unsigned NUM_BANKS  = 8;
   localparam int unsigned SEL_W      = $clog2(NUM_BANKS);

   // Write targets keyed by {addr[15], addr[14], addr[13], addr[0]}
   typedef enum logic [3:0] {
      KEY_SELECT = 4'b1000,
      KEY_BANK   = 4'b1001,
      KEY_MIRROR = 4'b1010,
      KEY_RAMCTL = 4'b1011
   } wr_key_e;

   typedef struct packed {
      logic             chr_swap;
      logic             prg_swap;
      logic [SEL_W-1:0] sel;
      logic             mirror;
      logic             ram_en;
      logic             ram_wp;
   } ctl_t;

endpackage

// File: rtl/bmap_regfile.sv
module bmap_regfile
   import bmap_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PRG_BANK_W = 6
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [DATA_W-1:0]                wr_data,
   output ctl_t                             ctl_o,
   output logic [NUM_BANKS-1:0][DATA_W-1:0] banks_o
);

   localparam logic [DATA_W-1:0] MASK_EVEN = ~{{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] MASK_FULL = '1;
   localparam logic [DATA_W-1:0] MASK_PRG  = DATA_W'((1 << PRG_BANK_W) - 1);

   wr_key_e key;
   logic    hit;
   ctl_t    ctl_q;

   assign key = wr_key_e'({wr_addr[ADDR_W-1 -: 3], wr_addr[0]});
   assign hit = wr_en && wr_addr[ADDR_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '{chr_swap: 1'b0, prg_swap: 1'b0, sel: '0,
                    mirror: 1'b0, ram_en: 1'b1, ram_wp: 1'b0};
      end else if (hit) begin
         case (key)
            KEY_SELECT: begin
               ctl_q.chr_swap <= wr_data[7];
               ctl_q.prg_swap <= wr_data[6];
               ctl_q.sel      <= wr_data[SEL_W-1:0];
            end
            KEY_MIRROR: ctl_q.mirror <= wr_data[0];
            KEY_RAMCTL: begin
               ctl_q.ram_en <= wr_data[7];
               ctl_q.ram_wp <= wr_data[6];
            end
            default: ;
         endcase
      end
   end

   // One register per bank slot; the stored mask depends on the slot
   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      localparam logic [DATA_W-1:0] MASK =
         (g < 2) ? MASK_EVEN : ((g < 6) ? MASK_FULL : MASK_PRG);
      logic [DATA_W-1:0] bank_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bank_q <= '0;
         end else if (hit && key == KEY_BANK && ctl_q.sel == SEL_W'(g)) begin
            bank_q <= wr_data & MASK;
         end
      end

      assign banks_o[g] = bank_q;
   end

   assign ctl_o = ctl_q;

   logic unused_addr;
   assign unused_addr = ^wr_addr[ADDR_W-4:1];

   // R1: a select write takes effect on the next edge
   p_select_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && key == KEY_SELECT) |=>
         (ctl_o.sel == $past(wr_data[SEL_W-1:0]) &&
          ctl_o.chr_swap == $past(wr_data[7]) && ctl_o.prg_swap == $past(wr_data[6])));

   // R2: program bank slots keep only the low bits
   p_prg_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && key == KEY_BANK && ctl_o.sel == SEL_W'(7)) |=>
         (banks_o[7] == ($past(wr_data) & MASK_PRG)));

   // R3: no qualifying write, no state change
   p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr[ADDR_W-1]) |=> ($stable(ctl_o) && $stable(banks_o)));

endmodule

// File: rtl/bmap_prg_xlate.sv
module bmap_prg_xlate
   import bmap_pkg::*;
#(
   parameter int unsigned PRG_BANK_W = 6
) (
   input  logic                            prg_swap,
   input  logic [PRG_BANK_W-1:0]           bank_a,
   input  logic [PRG_BANK_W-1:0]           bank_b,
   input  logic [PRG_OFS_W+1:0]            cpu_addr,
   output logic [PRG_BANK_W+PRG_OFS_W-1:0] rom_addr
);

   localparam logic [PRG_BANK_W-1:0] BANK_LAST = '1;
   localparam logic [PRG_BANK_W-1:0] BANK_NEXT = BANK_LAST - 1'b1;

   logic [1:0]            win;
   logic [PRG_BANK_W-1:0] bank;

   assign win = cpu_addr[PRG_OFS_W+1:PRG_OFS_W];

   always_comb begin
      unique case (win)
         2'd0:    bank = prg_swap ? BANK_NEXT : bank_a;
         2'd1:    bank = bank_b;
         2'd2:    bank = prg_swap ? bank_a : BANK_NEXT;
         default: bank = BANK_LAST;
      endcase
   end

   assign rom_addr = {bank, cpu_addr[PRG_OFS_W-1:0]};

endmodule

// File: rtl/bmap_chr_xlate.sv
module bmap_chr_xlate
   import bmap_pkg::*;
#(
   parameter int unsigned CHR_BANK_W = 8
) (
   input  logic                                 chr_swap,
   input  logic [NUM_BANKS-2-1:0][CHR_BANK_W-1:0] banks,
   input  logic [CHR_OFS_W+2:0]                 vid_addr,
   output logic [CHR_BANK_W+CHR_OFS_W-1:0]      rom_addr
);

   localparam int unsigned OUT_W = CHR_BANK_W + CHR_OFS_W;

   logic            fine_half;
   logic [1:0]      quarter;
   logic [OUT_W-1:0] wide_addr;
   logic [OUT_W-1:0] fine_addr;

   // Which pattern half holds the four 1 KB banks
   assign fine_half = vid_addr[CHR_OFS_W+2] ^ chr_swap;
   assign quarter   = vid_addr[CHR_OFS_W+1:CHR_OFS_W];

   // 2 KB banks: low bank bit is already zero, OR in an 11-bit offset
   assign wide_addr = {banks[quarter[1]], {CHR_OFS_W{1'b0}}} |
                      OUT_W'(vid_addr[CHR_OFS_W:0]);

   // 1 KB banks live in slots 2 to 5
   assign fine_addr = {banks[3'd2 + {1'b0, quarter}], vid_addr[CHR_OFS_W-1:0]};

   assign rom_addr = fine_half ? fine_addr : wide_addr;

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
   import bmap_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned VID_W      = 14,
   parameter int unsigned PRG_BANK_W = 6,
   parameter int unsigned CHR_BANK_W = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic                              cpu_rd,
   input  logic [ADDR_W-1:0]                 cpu_addr,
   input  logic [VID_W-1:0]                  vid_addr,
   input  logic [DATA_W-1:0]                 wram_rdata,
   output logic [PRG_BANK_W+PRG_OFS_W-1:0]   prg_rom_addr,
   output logic [CHR_BANK_W+CHR_OFS_W-1:0]   chr_rom_addr,
   output logic [CHR_OFS_W:0]                nt_addr,
   output logic                              wram_rd_en,
   output logic                              wram_wr_en,
   output logic [DATA_W-1:0]                 wram_rdata_gated
);

   localparam logic [2:0] WRAM_TOP = 3'b011;

   initial begin
      a_width_addr: assert (ADDR_W == 16) else $error("ADDR_W must be 16");
      a_width_data: assert (DATA_W == 8) else $error("DATA_W must be 8");
      a_width_vid:  assert (VID_W >= CHR_OFS_W + 3) else $error("VID_W too small");
      a_width_prg:  assert (PRG_BANK_W >= 2 && PRG_BANK_W <= DATA_W)
                       else $error("PRG_BANK_W out of range");
      a_width_chr:  assert (CHR_BANK_W >= 1 && CHR_BANK_W <= DATA_W)
                       else $error("CHR_BANK_W out of range");
   end

   ctl_t                             ctl;
   logic [NUM_BANKS-1:0][DATA_W-1:0] banks;
   logic [NUM_BANKS-3:0][CHR_BANK_W-1:0] chr_banks;

   bmap_regfile #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .PRG_BANK_W (PRG_BANK_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .ctl_o   (ctl),
      .banks_o (banks)
   );

   bmap_prg_xlate #(
      .PRG_BANK_W (PRG_BANK_W)
   ) u_prg (
      .prg_swap (ctl.prg_swap),
      .bank_a   (banks[6][PRG_BANK_W-1:0]),
      .bank_b   (banks[7][PRG_BANK_W-1:0]),
      .cpu_addr (cpu_addr[PRG_OFS_W+1:0]),
      .rom_addr (prg_rom_addr)
   );

   for (genvar g = 0; g < NUM_BANKS - 2; g++) begin : g_chr_slice
      assign chr_banks[g] = banks[g][CHR_BANK_W-1:0];
   end

   bmap_chr_xlate #(
      .CHR_BANK_W (CHR_BANK_W)
   ) u_chr (
      .chr_swap (ctl.chr_swap),
      .banks    (chr_banks),
      .vid_addr (vid_addr[CHR_OFS_W+2:0]),
      .rom_addr (chr_rom_addr)
   );

   // Nametable fold: choose the address bit that picks the 1 KB page
   assign nt_addr = {ctl.mirror ? vid_addr[CHR_OFS_W+1] : vid_addr[CHR_OFS_W],
                     vid_addr[CHR_OFS_W-1:0]};

   // Work RAM gate
   logic cpu_in_wram;
   logic wr_in_wram;

   assign cpu_in_wram      = cpu_addr[ADDR_W-1 -: 3] == WRAM_TOP;
   assign wr_in_wram       = wr_addr[ADDR_W-1 -: 3] == WRAM_TOP;
   assign wram_rd_en       = cpu_rd && cpu_in_wram && ctl.ram_en;
   assign wram_wr_en       = wr_en && wr_in_wram && ctl.ram_en && !ctl.ram_wp;
   assign wram_rdata_gated = ctl.ram_en ? wram_rdata : '0;

   logic unused_bits;
   assign unused_bits = ^{vid_addr[VID_W-1:CHR_OFS_W+3],
                          cpu_addr[ADDR_W-4:PRG_OFS_W+2],
                          banks[6][DATA_W-1:PRG_BANK_W > DATA_W-1 ? 0 : PRG_BANK_W],
                          banks[7][DATA_W-1:PRG_BANK_W > DATA_W-1 ? 0 : PRG_BANK_W]};

   // R4: the top window never moves
   p_top_window_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[PRG_OFS_W+1:PRG_OFS_W] == 2'b11) |->
         (prg_rom_addr[PRG_BANK_W+PRG_OFS_W-1:PRG_OFS_W] == {PRG_BANK_W{1'b1}}));

   // R5: with the program swap set, window 0 sits on the second-last bank
   p_swap_low_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.prg_swap && cpu_addr[PRG_OFS_W+1:PRG_OFS_W] == 2'b00) |->
         (prg_rom_addr[PRG_BANK_W+PRG_OFS_W-1:PRG_OFS_W] ==
          {{(PRG_BANK_W-1){1'b1}}, 1'b0}));

   // R6: first 2 KB region in pattern mode 0 follows slot 0
   p_chr_first_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.chr_swap && vid_addr[CHR_OFS_W+2:CHR_OFS_W+1] == 2'b00) |->
         (chr_rom_addr[CHR_BANK_W+CHR_OFS_W-1:CHR_OFS_W+1] ==
          banks[0][CHR_BANK_W-1:1]));

   // R9: a protected or disabled RAM never sees a write enable
   p_wram_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wram_wr_en |-> (ctl.ram_en && !ctl.ram_wp && wr_en));

endmodule

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        cpu_rd = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [13:0] vid_addr = '0;
   logic [7:0]  wram_rdata = 8'hA5;
   logic [18:0] prg_rom_addr;
   logic [17:0] chr_rom_addr;
   logic [10:0] nt_addr;
   logic        wram_rd_en;
   logic        wram_wr_en;
   logic [7:0]  wram_rdata_gated;

   int n_checks = 0;
   int n_fails  = 0;

   // Bench-side model of the programmed state
   logic [7:0] sh_bank [8];
   logic       sh_chr_m, sh_prg_m;
   logic [2:0] sh_sel;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_mapper u_dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .wr_en            (wr_en),
      .wr_addr          (wr_addr),
      .wr_data          (wr_data),
      .cpu_rd           (cpu_rd),
      .cpu_addr         (cpu_addr),
      .vid_addr         (vid_addr),
      .wram_rdata       (wram_rdata),
      .prg_rom_addr     (prg_rom_addr),
      .chr_rom_addr     (chr_rom_addr),
      .nt_addr          (nt_addr),
      .wram_rd_en       (wram_rd_en),
      .wram_wr_en       (wram_wr_en),
      .wram_rdata_gated (wram_rdata_gated)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [18:0] exp_prg(input logic [15:0] a);
      logic [5:0] b;
      case (a[14:13])
         2'd0: b = sh_prg_m ? 6'h3E : sh_bank[6][5:0];
         2'd1: b = sh_bank[7][5:0];
         2'd2: b = sh_prg_m ? sh_bank[6][5:0] : 6'h3E;
         default: b = 6'h3F;
      endcase
      return {b, a[12:0]};
   endfunction

   function automatic logic [17:0] exp_chr(input logic [13:0] a);
      logic upper;
      upper = a[12] ^ sh_chr_m;
      if (!upper) return {sh_bank[a[11]], 10'b0} | {7'b0, a[10:0]};
      return {sh_bank[2 + a[11:10]], a[9:0]};
   endfunction

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_select(input logic cm, input logic pm, input logic [2:0] s);
      bus_write(16'h8000, {cm, pm, 3'b000, s});
      sh_chr_m = cm; sh_prg_m = pm; sh_sel = s;
   endtask

   task automatic load_bank(input logic [2:0] s, input logic [7:0] d);
      set_select(sh_chr_m, sh_prg_m, s);
      bus_write(16'h8001, d);
      if (s < 2)      sh_bank[s] = d & 8'hFE;
      else if (s < 6) sh_bank[s] = d;
      else            sh_bank[s] = d & 8'h3F;
   endtask

   task automatic sweep_prg(input string req);
      for (int w = 0; w < 4; w++) begin
         cpu_addr = 16'h8000 | 16'(w << 13) | 16'h0ABC;
         #1;
         check(req, 32'(prg_rom_addr), 32'(exp_prg(cpu_addr)));
      end
   endtask

   task automatic sweep_chr(input string req);
      for (int r = 0; r < 8; r++) begin
         vid_addr = 14'(r << 10) | 14'h0155 | 14'(r[0] ? 14'h0 : 14'h0);
         #1;
         check(req, 32'(chr_rom_addr), 32'(exp_chr(vid_addr)));
         vid_addr = vid_addr | 14'h0200;
         #1;
         check(req, 32'(chr_rom_addr), 32'(exp_chr(vid_addr)));
      end
   endtask

   task automatic t_reset;
      cpu_rd = 1'b1; cpu_addr = 16'h6000; vid_addr = 14'h1234;
      #1;
      check("R10 chr after reset", 32'(chr_rom_addr), 32'h0234);
      check("R10 wram read enabled after reset", 32'(wram_rd_en), 32'h1);
      check("R10 gated data after reset", 32'(wram_rdata_gated), 32'hA5);
      cpu_addr = 16'h8123; #1;
      check("R10 prg window0 after reset", 32'(prg_rom_addr), 32'h00123);
      cpu_addr = 16'hE456; #1;
      check("R10 prg window3 after reset", 32'(prg_rom_addr), 32'h7E456);
      vid_addr = 14'h2C05; #1;
      check("R10 nt mirror 0 after reset", 32'(nt_addr), 32'h405);
      cpu_rd = 1'b0;
   endtask

   task automatic t_bank_loads;
      load_bank(3'd0, 8'h37);
      load_bank(3'd1, 8'hFF);
      load_bank(3'd2, 8'h12);
      load_bank(3'd3, 8'h34);
      load_bank(3'd4, 8'h56);
      load_bank(3'd5, 8'h78);
      load_bank(3'd6, 8'hC5);
      load_bank(3'd7, 8'h4A);
      vid_addr = 14'h0001; #1;
      check("R2 slot0 low bit cleared", 32'(chr_rom_addr), 32'h0D801);
      cpu_addr = 16'hA000; #1;
      check("R2 slot7 masked to 6 bits", 32'(prg_rom_addr), 32'h14000);
   endtask

   task automatic t_prg_modes;
      set_select(1'b0, 1'b0, 3'd0);
      sweep_prg("R4 R5 prg mode 0");
      set_select(1'b0, 1'b1, 3'd0);
      sweep_prg("R4 R5 prg mode 1");
      cpu_addr = 16'h8000; #1;
      check("R5 mode1 window0 fixed", 32'(prg_rom_addr), 32'h7C000);
      set_select(1'b0, 1'b0, 3'd0);
      cpu_addr = 16'hC001; #1;
      check("R1 prg mode bit cleared again", 32'(prg_rom_addr), 32'h7C001);
   endtask

   task automatic t_chr_modes;
      set_select(1'b0, 1'b0, 3'd0);
      sweep_chr("R6 chr mode 0");
      set_select(1'b1, 1'b0, 3'd0);
      sweep_chr("R7 chr mode 1");
      vid_addr = 14'h1801; #1;
      check("R7 upper 2KB uses slot1", 32'(chr_rom_addr), 32'h3F801);
      set_select(1'b0, 1'b0, 3'd0);
   endtask

   task automatic t_alias_and_ignored;
      bus_write(16'hBFFE, 8'h01);
      vid_addr = 14'h2C05; #1;
      check("R3 R8 alias write sets mirror", 32'(nt_addr), 32'h405);
      vid_addr = 14'h2805; #1;
      check("R8 mirror 1 takes bit 11", 32'(nt_addr), 32'h405);
      vid_addr = 14'h2405; #1;
      check("R8 mirror 1 ignores bit 10", 32'(nt_addr), 32'h005);
      bus_write(16'h9FFE, 8'hC3);
      sh_chr_m = 1'b1; sh_prg_m = 1'b1; sh_sel = 3'd3;
      sweep_prg("R3 alias select write prg");
      bus_write(16'h0001, 8'hEE);
      bus_write(16'h7FFF, 8'hEE);
      bus_write(16'hC001, 8'hEE);
      bus_write(16'hE000, 8'hEE);
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 16'h8001; wr_data = 8'hEE;
      @(negedge clk);
      sweep_chr("R3 ignored writes chr");
      sweep_prg("R3 ignored writes prg");
      bus_write(16'hA000, 8'h00);
      vid_addr = 14'h2805; #1;
      check("R8 mirror back to 0", 32'(nt_addr), 32'h005);
   endtask

   task automatic t_wram;
      bus_write(16'hA001, 8'hC0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 16'h6010; cpu_rd = 1'b1; cpu_addr = 16'h7FFF;
      #1;
      check("R9 protected blocks write", 32'(wram_wr_en), 32'h0);
      check("R9 protected still readable", 32'(wram_rd_en), 32'h1);
      wr_en = 1'b0;
      bus_write(16'hA001, 8'h00);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 16'h6010; cpu_addr = 16'h6000;
      #1;
      check("R9 disabled no write", 32'(wram_wr_en), 32'h0);
      check("R9 disabled no read", 32'(wram_rd_en), 32'h0);
      check("R9 disabled reads zero", 32'(wram_rdata_gated), 32'h00);
      wr_en = 1'b0;
      bus_write(16'hA001, 8'h80);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 16'h6010; cpu_addr = 16'h8000;
      #1;
      check("R9 enabled write", 32'(wram_wr_en), 32'h1);
      check("R9 read outside window", 32'(wram_rd_en), 32'h0);
      check("R9 enabled data passes", 32'(wram_rdata_gated), 32'hA5);
      wr_addr = 16'h8010; #1;
      check("R9 write outside window", 32'(wram_wr_en), 32'h0);
      wr_en = 1'b0; cpu_rd = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 8; i++) sh_bank[i] = 8'h00;
      sh_chr_m = 1'b0; sh_prg_m = 1'b0; sh_sel = 3'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bank_loads();
      t_prg_modes();
      t_chr_modes();
      t_alias_and_ignored();
      t_wram();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule